// File: doc/BRIEF.md
# Two-Wire Half-Duplex Command Slave

This block is the slave end of a two-wire host link. One wire is a shared open-drain data line that carries asynchronous serial bytes (one start bit, eight data bits sent LSB first, one stop bit). The other is an open-drain enable line that both ends may pull low. The block never drives either wire high. It only asserts a drive-low enable, and a released wire is pulled up outside the chip.

The host opens a transaction by pulling the enable line low. It then sends a command byte and any parameter bytes. The slave queues these bytes and passes them to a command executor as a valid/ready stream, with the first byte marked as the command. When the host releases the enable line, the slave turns the bus around. It pulls the enable line low itself and transmits a status byte that it builds on its own. It then transmits any response bytes that the executor streams in, waits until its transmitter has drained, and releases the line.

The serial rate is set by the number of clocks per bit. The executor decides what each command means and how many response bytes follow. This block only sequences the transaction and keeps the status flags.

Top module: `hostlink_slave`

## Requirements
- R1: After reset, `dq_oe`, `we_oe`, `cmd_valid` and `rsp_ready` are all 0.
- R2: A falling edge on the enable line while the slave is not responding starts command reception. The first byte received is presented with `cmd_is_cmd`=1, and every later byte with `cmd_is_cmd`=0, in arrival order. A new falling edge discards any bytes still queued.
- R3: A received command byte whose bit 7 is 1 is presented as 0x7F and counts as an invalid command.
- R4: A command code of `NUM_CMDS` or above sets the invalid flag, and the parameter bytes that follow it are never presented to the executor.
- R5: A rising edge on the enable line during reception makes the slave assert `we_oe`. `we_oe` stays asserted until the stop bit of the last byte it transmits has ended, and then it drops.
- R6: The first byte sent after turnaround is the status byte. Bit 0 is invalid command. Bit 1 is parameter missing: a command sets it and a `param_ack` pulse clears it. Bit 2 is buffer overrun. Bit 3 is parity error: a `perr_set` pulse sets it and the next command clears it. Bits 7..4 are 0.
- R7: Response bytes accepted on the `rsp_valid`/`rsp_ready` handshake are transmitted after the status byte, in order. `rsp_ready` is 1 only in the data phase. The data phase ends when `rsp_end` is 1 and no byte is pending.
- R8: A byte that arrives while the receive queue is full sets the overrun flag and is dropped. The flag is cleared once the status byte has been queued, so the next transaction reports bit 2 = 0.
- R9: Bytes are framed as one low start bit, eight data bits LSB first and one high stop bit, each `CLKS_PER_BIT` clocks long. The slave only drives the data line while it is responding.
- R10: Bytes on the data line while no transaction is open are not presented to the executor and do not appear in a later transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dq_i | input | 1 | Level sensed on the shared data wire |
| dq_oe | output | 1 | Pull the data wire low |
| we_i | input | 1 | Level sensed on the enable wire |
| we_oe | output | 1 | Pull the enable wire low |
| cmd_valid | output | 1 | A command or parameter byte is offered |
| cmd_ready | input | 1 | Executor takes the offered byte |
| cmd_data | output | 8 | Offered byte (command code after mapping) |
| cmd_is_cmd | output | 1 | Offered byte is the command byte |
| param_ack | input | 1 | Executor consumed its parameters; clears parameter-missing |
| perr_set | input | 1 | Raise the parity-error status flag |
| rsp_valid | input | 1 | Response byte offered by the executor |
| rsp_ready | output | 1 | Slave accepts the response byte |
| rsp_data | input | 8 | Response byte |
| rsp_end | input | 1 | No more response bytes |

## Verification
Transactions are tried with several command shapes. One is a valid command with parameters and response data. One is a command at the last legal code with no payload. Others are a code one past the range, a code with bit 7 set, and a response longer than the transmit queue. Together these show whether parameters are forwarded or dropped, whether the command mapping is right, and whether backpressure keeps the byte order. Status patterns separate each flag: missing acknowledge, injected parity error, and a receive queue overflowed by a stalled executor. Each flag-setting transaction is followed by a clean one, which proves the flag was cleared. A byte sent while no transaction is open checks that the receiver stays deaf.

// File: rtl/hl_pkg.sv
package hl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RXCMD = 3'd1,
      ST_RXPAR = 3'd2,
      ST_RSP   = 3'd3,
      ST_DATA  = 3'd4,
      ST_FIN   = 3'd5
   } hl_state_e;

   // status byte bit positions, decoded by the host
   localparam int STB_INVALID = 0;
   localparam int STB_PMISS   = 1;
   localparam int STB_OVR     = 2;
   localparam int STB_PERR    = 3;

   localparam logic [7:0] BAD_CMD = 8'h7F;
endpackage

// File: rtl/hl_fifo.sv
module hl_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNTW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
   localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

   logic [W-1:0]    mem [DEPTH];
   logic [AW-1:0]   wp, rp;
   logic [CNTW-1:0] cnt;
   logic            do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_FULL);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == PTR_LAST) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop)  rp <= nxt(rp);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end
endmodule

// File: rtl/hl_uart_rx.sv
module hl_uart_rx #(
   parameter int CPB        = 16,
   parameter bit STOP_CHECK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       line_i,
   output logic       valid,
   output logic [7:0] data
);
   localparam int CW = $clog2(CPB);
   localparam logic [CW-1:0] LAST = CW'(CPB - 1);
   localparam logic [CW-1:0] MID  = CW'(CPB / 2 - 1);

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_st_e;

   rx_st_e        st;
   logic          s1, s2;
   logic [CW-1:0] cnt;
   logic [2:0]    nb;
   logic [7:0]    sh;
   logic          stop_ok;

   generate
      if (STOP_CHECK) begin : g_stop_chk
         assign stop_ok = s2;
      end else begin : g_stop_free
         assign stop_ok = 1'b1;
      end
   endgenerate

   assign data = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1    <= 1'b1;
         s2    <= 1'b1;
         st    <= RX_IDLE;
         cnt   <= '0;
         nb    <= '0;
         sh    <= '0;
         valid <= 1'b0;
      end else begin
         s1    <= line_i;
         s2    <= s1;
         valid <= 1'b0;
         if (!en) begin
            st <= RX_IDLE;
         end else begin
            case (st)
               RX_IDLE: if (!s2) begin
                  st  <= RX_START;
                  cnt <= '0;
               end
               RX_START: if (cnt == MID) begin
                  cnt <= '0;
                  nb  <= '0;
                  st  <= s2 ? RX_IDLE : RX_BITS;
               end else cnt <= cnt + 1'b1;
               RX_BITS: if (cnt == LAST) begin
                  cnt <= '0;
                  sh  <= {s2, sh[7:1]};
                  nb  <= nb + 1'b1;
                  if (nb == 3'd7) st <= RX_STOP;
               end else cnt <= cnt + 1'b1;
               RX_STOP: if (cnt == LAST) begin
                  st    <= RX_IDLE;
                  valid <= stop_ok;
               end else cnt <= cnt + 1'b1;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/hl_uart_tx.sv
module hl_uart_tx #(
   parameter int CPB = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] din,
   output logic       busy,
   output logic       drive_low
);
   localparam int CW = $clog2(CPB);
   localparam logic [CW-1:0] LAST = CW'(CPB - 1);

   logic [9:0]    sh;
   logic [CW-1:0] cnt;
   logic [3:0]    nb;

   assign drive_low = busy && !sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         cnt  <= '0;
         nb   <= '0;
         busy <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            sh   <= {1'b1, din, 1'b0};
            cnt  <= '0;
            nb   <= '0;
            busy <= 1'b1;
         end
      end else if (cnt == LAST) begin
         cnt <= '0;
         if (nb == 4'd9) begin
            busy <= 1'b0;
         end else begin
            nb <= nb + 1'b1;
            sh <= {1'b1, sh[9:1]};
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hostlink_slave.sv
module hostlink_slave #(
   parameter int CLKS_PER_BIT = 2083,
   parameter int NUM_CMDS     = 16,
   parameter int RXQ_DEPTH    = 8,
   parameter int TXQ_DEPTH    = 8,
   parameter bit STOP_CHECK   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dq_i,
   output logic       dq_oe,
   input  logic       we_i,
   output logic       we_oe,
   output logic       cmd_valid,
   input  logic       cmd_ready,
   output logic [7:0] cmd_data,
   output logic       cmd_is_cmd,
   input  logic       param_ack,
   input  logic       perr_set,
   input  logic       rsp_valid,
   output logic       rsp_ready,
   input  logic [7:0] rsp_data,
   input  logic       rsp_end
);
   import hl_pkg::*;

   localparam logic [7:0] NCMD_B = 8'(NUM_CMDS);

   generate
      if (CLKS_PER_BIT < 4) begin : g_bad_cpb
         $error("CLKS_PER_BIT must be at least 4");
      end
      if (NUM_CMDS < 1 || NUM_CMDS > 127) begin : g_bad_ncmd
         $error("NUM_CMDS must be within 1..127");
      end
      if (RXQ_DEPTH < 2 || TXQ_DEPTH < 2) begin : g_bad_depth
         $error("queue depths must be at least 2");
      end
   endgenerate

   hl_state_e st, st_nx;
   logic we_s1, we_s2, we_d;
   logic we_fall, we_rise, receiving, responding, fall_take, rise_take;
   logic rx_vld;
   logic [7:0] rx_byte;
   logic rxq_pop, rxq_empty, rxq_full;
   logic [7:0] rxq_dout, cmd_code;
   logic pop_cmd;
   logic txq_push, txq_empty, txq_full;
   logic [7:0] txq_din, txq_dout, status_byte;
   logic tx_go, tx_busy, tx_low;
   logic flg_invalid, flg_pmiss, flg_ovr, flg_perr, ovr_set;

   // enable wire: two-flop synchroniser, then edge detect
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_s1 <= 1'b1;
         we_s2 <= 1'b1;
         we_d  <= 1'b1;
      end else begin
         we_s1 <= we_i;
         we_s2 <= we_s1;
         we_d  <= we_s2;
      end
   end

   assign we_fall    = we_d && !we_s2;
   assign we_rise    = !we_d && we_s2;
   assign receiving  = (st == ST_RXCMD) || (st == ST_RXPAR);
   assign responding = (st == ST_RSP) || (st == ST_DATA) || (st == ST_FIN);
   assign fall_take  = we_fall && !responding;
   assign rise_take  = we_rise && receiving;

   hl_uart_rx #(.CPB(CLKS_PER_BIT), .STOP_CHECK(STOP_CHECK)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(receiving), .line_i(dq_i),
      .valid(rx_vld), .data(rx_byte)
   );

   hl_fifo #(.W(8), .DEPTH(RXQ_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(fall_take), .push(rx_vld), .din(rx_byte),
      .pop(rxq_pop), .dout(rxq_dout), .empty(rxq_empty), .full(rxq_full)
   );

   assign cmd_code   = rxq_dout[7] ? BAD_CMD : rxq_dout;
   assign cmd_is_cmd = (st == ST_RXCMD);
   assign cmd_data   = cmd_is_cmd ? cmd_code : rxq_dout;
   assign cmd_valid  = !rxq_empty &&
                       ((st == ST_RXCMD) || ((st == ST_RXPAR) && !flg_invalid));
   assign pop_cmd    = (st == ST_RXCMD) && !rxq_empty && cmd_ready;
   assign rxq_pop    = pop_cmd ||
                       ((st == ST_RXPAR) && !rxq_empty && (flg_invalid || cmd_ready));

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE:  if (fall_take) st_nx = ST_RXCMD;
         ST_RXCMD: begin
            if (rise_take)      st_nx = ST_RSP;
            else if (fall_take) st_nx = ST_RXCMD;
            else if (pop_cmd)   st_nx = ST_RXPAR;
         end
         ST_RXPAR: begin
            if (rise_take)      st_nx = ST_RSP;
            else if (fall_take) st_nx = ST_RXCMD;
         end
         ST_RSP:   st_nx = ST_DATA;
         ST_DATA:  if (rsp_end && !(rsp_valid && !rsp_ready)) st_nx = ST_FIN;
         ST_FIN:   if (txq_empty && !tx_busy) st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   always_comb begin
      status_byte = '0;
      status_byte[STB_INVALID] = flg_invalid;
      status_byte[STB_PMISS]   = flg_pmiss;
      status_byte[STB_OVR]     = flg_ovr;
      status_byte[STB_PERR]    = flg_perr;
   end

   assign rsp_ready = (st == ST_DATA) && !txq_full;
   assign txq_push  = (st == ST_RSP) || ((st == ST_DATA) && rsp_valid && rsp_ready);
   assign txq_din   = (st == ST_RSP) ? status_byte : rsp_data;
   assign tx_go     = responding && !txq_empty && !tx_busy;
   assign ovr_set   = (rx_vld && rxq_full) || (txq_push && txq_full);

   hl_fifo #(.W(8), .DEPTH(TXQ_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(fall_take), .push(txq_push), .din(txq_din),
      .pop(tx_go), .dout(txq_dout), .empty(txq_empty), .full(txq_full)
   );

   hl_uart_tx #(.CPB(CLKS_PER_BIT)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_go), .din(txq_dout),
      .busy(tx_busy), .drive_low(tx_low)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_invalid <= 1'b0;
         flg_pmiss   <= 1'b0;
         flg_ovr     <= 1'b0;
         flg_perr    <= 1'b0;
      end else begin
         if (pop_cmd) begin
            flg_invalid <= (cmd_code >= NCMD_B);
            flg_pmiss   <= 1'b1;
            flg_perr    <= 1'b0;
         end else begin
            if (param_ack) flg_pmiss <= 1'b0;
            if (perr_set)  flg_perr  <= 1'b1;
         end
         if (st == ST_RSP) flg_ovr <= ovr_set;
         else              flg_ovr <= flg_ovr || ovr_set;
      end
   end

   assign we_oe = responding;
   assign dq_oe = tx_low;
endmodule

// File: rtl/hl_slave_chk.sv
module hl_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       we_oe,
   input logic       dq_oe,
   input logic       cmd_valid,
   input logic       cmd_is_cmd,
   input logic [7:0] cmd_data,
   input logic       rsp_ready,
   input logic       tx_busy,
   input logic       txq_empty,
   input logic       flg_invalid
);
   AST_CMD_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !we_oe); // R2

   AST_CMD_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_is_cmd) |-> !cmd_data[7]); // R3

   AST_PARAM_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_is_cmd) |-> !flg_invalid); // R4

   AST_RELEASE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_oe) |-> (!tx_busy && txq_empty)); // R5

   AST_RSP_IN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> we_oe); // R7

   AST_DQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !we_oe |-> !dq_oe); // R9
endmodule

bind hostlink_slave hl_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .we_oe(we_oe), .dq_oe(dq_oe),
   .cmd_valid(cmd_valid), .cmd_is_cmd(cmd_is_cmd), .cmd_data(cmd_data),
   .rsp_ready(rsp_ready), .tx_busy(tx_busy), .txq_empty(txq_empty),
   .flg_invalid(flg_invalid)
);

// File: tb/sim_hostlink_slave.sv
module sim_hostlink_slave;
   localparam int CLK_PERIOD = 10;
   localparam int CPB        = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_dq_low = 1'b0, host_we_low = 1'b0;
   logic dq_oe, we_oe, dq_line, we_line;
   logic cmd_valid, cmd_ready = 1'b1, cmd_is_cmd;
   logic [7:0] cmd_data;
   logic param_ack = 1'b0, perr_set = 1'b0;
   logic rsp_valid, rsp_ready, rsp_end;
   logic [7:0] rsp_data;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   logic [7:0] tx_buf [16];
   logic [7:0] rsp_buf [16];
   logic [7:0] cap_d [16];
   logic       cap_c [16];
   int cap_n = 0, rsp_idx = 0, rsp_n = 0;
   logic cap_clr = 1'b0, rsp_load = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign dq_line   = !(host_dq_low || dq_oe);
   assign we_line   = !(host_we_low || we_oe);
   assign rsp_valid = (rsp_idx < rsp_n);
   assign rsp_data  = rsp_buf[rsp_idx];
   assign rsp_end   = !rsp_valid;

   hostlink_slave #(.CLKS_PER_BIT(CPB), .NUM_CMDS(16), .RXQ_DEPTH(4),
                    .TXQ_DEPTH(4), .STOP_CHECK(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .dq_i(dq_line), .dq_oe(dq_oe),
      .we_i(we_line), .we_oe(we_oe), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_data(cmd_data), .cmd_is_cmd(cmd_is_cmd), .param_ack(param_ack),
      .perr_set(perr_set), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_data(rsp_data), .rsp_end(rsp_end)
   );

   // executor model: capture the command stream, feed the response stream
   always @(posedge clk) begin
      if (cap_clr) cap_n <= 0;
      else if (cmd_valid && cmd_ready && cap_n < 16) begin
         cap_d[cap_n] <= cmd_data;
         cap_c[cap_n] <= cmd_is_cmd;
         cap_n <= cap_n + 1;
      end
      if (rsp_load) rsp_idx <= 0;
      else if (rsp_valid && rsp_ready) rsp_idx <= rsp_idx + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_send(input logic [7:0] b);
      @(negedge clk);
      host_dq_low = 1'b1;
      repeat (CPB) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         host_dq_low = !b[i];
         repeat (CPB) @(negedge clk);
      end
      host_dq_low = 1'b0;
      repeat (2*CPB) @(negedge clk);
   endtask

   // R9: framing of bytes sent by the slave
   task automatic slave_recv(output logic [7:0] b, output bit ok);
      ok = 1'b0;
      b  = '0;
      for (int k = 0; k < 4000 && !ok; k++) begin
         @(negedge clk);
         if (!dq_line) ok = 1'b1;
      end
      if (ok) begin
         repeat (CPB + CPB/2) @(negedge clk);
         b[0] = dq_line;
         for (int i = 1; i < 8; i++) begin
            repeat (CPB) @(negedge clk);
            b[i] = dq_line;
         end
         repeat (CPB) @(negedge clk);
         chk(dq_line == 1'b1, "R9 stop bit", dq_line, 1);
      end
   endtask

   task automatic txn(input int nb, input int nd, input bit ack, input bit perr,
                      input bit stall, input logic [7:0] exp_st);
      logic [7:0] b;
      bit ok, rel;
      @(negedge clk);
      cap_clr = 1'b1; rsp_load = 1'b1; rsp_n = nd;
      @(negedge clk);
      cap_clr = 1'b0; rsp_load = 1'b0;
      if (stall) cmd_ready = 1'b0;
      host_we_low = 1'b1;
      repeat (6) @(negedge clk);
      for (int i = 0; i < nb; i++) host_send(tx_buf[i]);
      cmd_ready = 1'b1;
      repeat (2*CPB) @(negedge clk);
      if (ack) begin param_ack = 1'b1; @(negedge clk); param_ack = 1'b0; end
      if (perr) begin perr_set = 1'b1; @(negedge clk); perr_set = 1'b0; end
      host_we_low = 1'b0;
      repeat (8) @(negedge clk);
      chk(we_oe && !we_line, "R5 enable held by slave", we_oe, 1);
      slave_recv(b, ok);
      chk(ok && b == exp_st, "R6 status byte", b, exp_st);
      for (int i = 0; i < nd; i++) begin
         slave_recv(b, ok);
         chk(ok && b == rsp_buf[i], "R7 response byte", b, rsp_buf[i]);
      end
      rel = 1'b0;
      for (int k = 0; k < 4*CPB && !rel; k++) begin
         @(negedge clk);
         if (!we_oe) rel = 1'b1;
      end
      chk(rel && dq_line, "R5 enable released", we_oe, 0);
      repeat (4*CPB) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(!dq_oe && !we_oe && !cmd_valid && !rsp_ready, "R1 reset outputs",
          {dq_oe, we_oe, cmd_valid, rsp_ready}, 0);
   endtask

   task automatic t_basic;
      tx_buf[0] = 8'h05; tx_buf[1] = 8'hA5; tx_buf[2] = 8'h3C;
      rsp_buf[0] = 8'h11; rsp_buf[1] = 8'hE7;
      txn(3, 2, 1'b1, 1'b0, 1'b0, 8'h00);
      chk(cap_n == 3, "R2 byte count", cap_n, 3);
      chk(cap_d[0] == 8'h05 && cap_c[0], "R2 command byte", cap_d[0], 8'h05);
      chk(cap_d[1] == 8'hA5 && !cap_c[1], "R2 first parameter", cap_d[1], 8'hA5);
      chk(cap_d[2] == 8'h3C && !cap_c[2], "R2 second parameter", cap_d[2], 8'h3C);
   endtask

   task automatic t_last_code;
      tx_buf[0] = 8'h0F;
      txn(1, 0, 1'b0, 1'b0, 1'b0, 8'h02);
      chk(cap_n == 1 && cap_d[0] == 8'h0F, "R6 last code no ack", cap_d[0], 8'h0F);
   endtask

   task automatic t_out_of_range;
      tx_buf[0] = 8'h10; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02;
      txn(3, 0, 1'b0, 1'b0, 1'b0, 8'h03);
      chk(cap_n == 1, "R4 parameters dropped", cap_n, 1);
   endtask

   task automatic t_msb_cmd;
      tx_buf[0] = 8'h85; tx_buf[1] = 8'h44;
      txn(2, 0, 1'b0, 1'b0, 1'b0, 8'h03);
      chk(cap_n == 1 && cap_d[0] == 8'h7F, "R3 mapped command", cap_d[0], 8'h7F);
   endtask

   task automatic t_parity;
      tx_buf[0] = 8'h02;
      txn(1, 0, 1'b1, 1'b1, 1'b0, 8'h08);
      txn(1, 0, 1'b1, 1'b0, 1'b0, 8'h00); // R6 parity flag cleared by command
   endtask

   task automatic t_overrun;
      tx_buf[0] = 8'h03; tx_buf[1] = 8'hC1; tx_buf[2] = 8'hC2;
      tx_buf[3] = 8'hC3; tx_buf[4] = 8'hC4;
      txn(5, 0, 1'b0, 1'b0, 1'b1, 8'h06);
      chk(cap_n == 4, "R8 fifth byte dropped", cap_n, 4);
      chk(cap_d[3] == 8'hC3, "R8 kept order", cap_d[3], 8'hC3);
      tx_buf[0] = 8'h03;
      txn(1, 0, 1'b1, 1'b0, 1'b0, 8'h00); // R8 overrun flag cleared
   endtask

   task automatic t_long_rsp;
      tx_buf[0] = 8'h07;
      for (int i = 0; i < 6; i++) rsp_buf[i] = 8'(8'h30 + i * 7);
      txn(1, 6, 1'b1, 1'b0, 1'b0, 8'h00); // R7 backpressure order
   endtask

   task automatic t_idle_deaf;
      @(negedge clk);
      cap_clr = 1'b1;
      @(negedge clk);
      cap_clr = 1'b0;
      host_send(8'h55);
      repeat (2*CPB) @(negedge clk);
      chk(cap_n == 0 && !cmd_valid, "R10 idle byte ignored", cap_n, 0);
      tx_buf[0] = 8'h01;
      txn(1, 0, 1'b1, 1'b0, 1'b0, 8'h00);
      chk(cap_n == 1 && cap_d[0] == 8'h01, "R10 no stale byte", cap_d[0], 8'h01);
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_last_code();
      t_out_of_range();
      t_msb_cmd();
      t_parity();
      t_overrun();
      t_long_rsp();
      t_idle_deaf();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule